// File: doc/BRIEF.md
# Fully Associative TLB with Write Protection

This block translates 32-bit virtual addresses into 28-bit physical addresses for 4 KiB pages. It holds a small set of mappings and searches all of them in parallel for the 20-bit virtual page number of each request. A hit replaces that page number with the stored 16-bit physical page number. The low 12 bits of the address pass through unchanged. Each entry carries a write-permission flag. The block also keeps a reference flag and a modified flag, which it updates on every successful access.

There is no hardware walker. A request that matches no valid mapping returns a miss exception pulse, and software then installs the mapping through the fill port. A write to a read-only page returns a protection exception pulse and leaves the entry unchanged. Software can invalidate every mapping in one cycle and clear all reference flags with one pulse. It can also read any entry back by index, including both status flags.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry reads back as invalid with dirty, reference and write-permission at 0. The response outputs are 0, and any lookup misses.
- R2: A lookup whose VPN (address bits 31:12) matches a valid entry returns, one cycle later, a hit pulse with physical address = {entry PPN, request bits 11:0}.
- R3: A lookup that matches no valid entry returns a miss-exception pulse with physical address 0. No entry changes.
- R4: A write that matches an entry whose write-permission bit is 0 returns a protection-exception pulse with physical address 0. The entry's dirty and reference bits are not set.
- R5: A write hit on a writable entry sets both the dirty bit and the reference bit of that entry.
- R6: A read hit sets the reference bit of the matching entry and leaves its dirty bit unchanged.
- R7: Hit, miss-exception and protection-exception are mutually exclusive. Exactly one of them pulses for one cycle in the cycle after each request, and none pulses in a cycle after no request.
- R8: A fill writes the VPN, PPN and write-permission bit into the indexed entry, sets valid, and clears dirty and reference. A fill overrides a status update from a lookup to the same entry in the same cycle, but that lookup is still answered from the old contents.
- R9: Invalidate-all clears every valid bit in one cycle. It takes precedence over a fill in the same cycle.
- R10: A clear-reference pulse zeroes every reference bit. A hit in the same cycle still leaves its own entry's reference bit at 1.
- R11: When several valid entries hold the same VPN, the lowest-indexed one supplies the translation and receives the status update.
- R12: The read-back outputs show, combinationally, the valid, dirty, reference and write-permission bits, the VPN and the PPN of the entry selected by the read index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_vaddr | input | 32 | Virtual address of the request |
| rsp_paddr | output | 28 | Translated physical address, 0 unless hit |
| rsp_hit | output | 1 | Successful translation pulse |
| rsp_miss | output | 1 | Miss-exception pulse |
| rsp_prot | output | 1 | Write-protection exception pulse |
| fill_en | input | 1 | Install a mapping |
| fill_idx | input | log2(ENTRIES) | Entry index to install into |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 16 | Physical page number to install |
| fill_wr_ok | input | 1 | Write permission of the installed page |
| inval_all | input | 1 | Clear every valid bit |
| clr_ref | input | 1 | Clear every reference bit |
| rd_idx | input | log2(ENTRIES) | Entry index for read-back |
| rd_valid | output | 1 | Read-back valid bit |
| rd_dirty | output | 1 | Read-back dirty bit |
| rd_ref | output | 1 | Read-back reference bit |
| rd_wr_ok | output | 1 | Read-back write-permission bit |
| rd_vpn | output | 20 | Read-back VPN |
| rd_ppn | output | 16 | Read-back PPN |

## Verification
The bench builds the block with ENTRIES = 4 and leaves the address widths at 32/28/12. With four entries the bench can fill every slot and use both the first and the last index. Four slots also leave room for two entries that share a VPN, which tests the lowest-index rule. The widths stay at their defaults so that the expected physical addresses come straight from the 16-bit page-number split.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 28,
  parameter int OFF_W   = 12,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PPN_W  = PA_W - OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_prot,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_wr_ok,
  input  logic             inval_all,
  input  logic             clr_ref,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic             rd_ref,
  output logic             rd_wr_ok,
  output logic [VPN_W-1:0] rd_vpn,
  output logic [PPN_W-1:0] rd_ppn
);

  typedef struct packed {
    logic             v;
    logic             d;
    logic             r;
    logic             w;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
  } ent_t;

  ent_t ent_q [ENTRIES];

  logic [VPN_W-1:0]   req_vpn;
  logic [ENTRIES-1:0] match;
  logic               found;
  logic [IDX_W-1:0]   sel;
  logic               denied;
  logic               grant;

  assign req_vpn = req_vaddr[VA_W-1:OFF_W];

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
  end

  assign denied = req_write && !ent_q[sel].w;
  assign grant  = req_valid && found && !denied;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic fill_me;
    logic use_me;
    assign match[g] = ent_q[g].v && (ent_q[g].vpn == req_vpn);
    assign fill_me  = fill_en && (fill_idx == IDX_W'(g));
    assign use_me   = grant && (sel == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else begin
        if (inval_all)    ent_q[g].v <= 1'b0;
        else if (fill_me) ent_q[g].v <= 1'b1;
        if (fill_me) begin
          ent_q[g].vpn <= fill_vpn;
          ent_q[g].ppn <= fill_ppn;
          ent_q[g].w   <= fill_wr_ok;
          ent_q[g].d   <= 1'b0;
          ent_q[g].r   <= 1'b0;
        end else if (use_me) begin
          ent_q[g].r <= 1'b1;
          if (req_write) ent_q[g].d <= 1'b1;
        end else if (clr_ref) begin
          ent_q[g].r <= 1'b0;
        end
      end
    end

    assert_dirty_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ent_q[g].d) |-> $past(req_valid && req_write));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_prot  <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_hit   <= grant;
      rsp_miss  <= req_valid && !found;
      rsp_prot  <= req_valid && found && denied;
      rsp_paddr <= grant ? {ent_q[sel].ppn, req_vaddr[OFF_W-1:0]} : '0;
    end
  end

  assign rd_valid = ent_q[rd_idx].v;
  assign rd_dirty = ent_q[rd_idx].d;
  assign rd_ref   = ent_q[rd_idx].r;
  assign rd_wr_ok = ent_q[rd_idx].w;
  assign rd_vpn   = ent_q[rd_idx].vpn;
  assign rd_ppn   = ent_q[rd_idx].ppn;

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_hit, rsp_miss, rsp_prot}));

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(rsp_hit || rsp_miss || rsp_prot));

  assert_answer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_hit || rsp_miss || rsp_prot));

  assert_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

  assert_fault_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_miss || rsp_prot) |-> rsp_paddr == '0);

  assert_inval_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> !rd_valid);

endmodule

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
  localparam int PERIOD = 10;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [27:0] rsp_paddr;
  logic        rsp_hit, rsp_miss, rsp_prot;
  logic        fill_en = 1'b0, fill_wr_ok = 1'b0, inval_all = 1'b0, clr_ref = 1'b0;
  logic [1:0]  fill_idx = '0, rd_idx = '0;
  logic [19:0] fill_vpn = '0, rd_vpn;
  logic [15:0] fill_ppn = '0, rd_ppn;
  logic        rd_valid, rd_dirty, rd_ref, rd_wr_ok;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  tlb_xlate #(.ENTRIES(N)) i_tlb_xlate (.*);

  // [62]=write [61:30]=vaddr [29:28]=code(1 hit,2 miss,3 prot) [27:0]=paddr
  localparam logic [62:0] VEC [8] = '{
    {1'b0, 32'hC0001560, 2'd1, 28'hA200560},
    {1'b0, 32'hC0006123, 2'd1, 28'hF5C0123},
    {1'b0, 32'hC0002450, 2'd2, 28'h0},
    {1'b1, 32'hC0000FFF, 2'd1, 28'hA204FFF},
    {1'b1, 32'hC0001000, 2'd3, 28'h0},
    {1'b1, 32'hC0003ABC, 2'd1, 28'h8003ABC},
    {1'b0, 32'h00000000, 2'd2, 28'h0},
    {1'b0, 32'hC0003001, 2'd1, 28'h8003001}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] code();
    if (rsp_hit && !rsp_miss && !rsp_prot) return 2'd1;
    if (rsp_miss && !rsp_hit && !rsp_prot) return 2'd2;
    if (rsp_prot && !rsp_hit && !rsp_miss) return 2'd3;
    return 2'd0;
  endfunction

  task automatic fill(input int idx, input logic [19:0] vpn, input logic [15:0] ppn, input logic w);
    @(negedge clk);
    fill_en = 1'b1; fill_idx = 2'(idx); fill_vpn = vpn; fill_ppn = ppn; fill_wr_ok = w;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic lookup(input logic w, input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 rsp", {rsp_hit, rsp_miss, rsp_prot, rsp_paddr}, '0);
    for (int i = 0; i < N; i++) begin
      rd_idx = 2'(i); #1;
      chk("R1 entry", {rd_valid, rd_dirty, rd_ref, rd_wr_ok}, '0);
    end
    lookup(1'b0, 32'h12345678);
    chk("R1 miss after reset", code(), 2'd2);
    // R7: no request, no pulse
    @(negedge clk);
    chk("R7 idle", {rsp_hit, rsp_miss, rsp_prot}, '0);

    // R8: fill and read back (R12)
    fill(0, 20'hC0000, 16'hA204, 1'b1);
    fill(1, 20'hC0001, 16'hA200, 1'b0);
    fill(2, 20'hC0006, 16'hF5C0, 1'b1);
    fill(3, 20'hC0003, 16'h8003, 1'b1);
    rd_idx = 2'd1; #1;
    chk("R8 R12 readback", {rd_valid, rd_dirty, rd_ref, rd_wr_ok, rd_vpn, rd_ppn},
        {4'b1000, 20'hC0001, 16'hA200});

    // R2 R3 R4 R7: vector table
    for (int k = 0; k < 8; k++) begin
      lookup(VEC[k][62], VEC[k][61:30]);
      chk("R2/R3/R4 code", code(), VEC[k][29:28]);
      chk("R2/R3/R4 paddr", rsp_paddr, VEC[k][27:0]);
    end
    // R5: writable write hit
    rd_idx = 2'd0; #1;
    chk("R5 dirty+ref", {rd_dirty, rd_ref}, 2'b11);
    // R4: protected entry not dirtied (ref only from earlier read)
    rd_idx = 2'd1; #1;
    chk("R4 no dirty", {rd_dirty, rd_ref}, 2'b01);
    // R6: read hit sets ref only
    rd_idx = 2'd2; #1;
    chk("R6 ref only", {rd_dirty, rd_ref}, 2'b01);

    // R10: clear ref, with same-cycle hit on entry 2
    @(negedge clk);
    clr_ref = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_vaddr = 32'hC0006000;
    @(negedge clk);
    clr_ref = 1'b0; req_valid = 1'b0;
    for (int i = 0; i < N; i++) begin
      rd_idx = 2'(i); #1;
      chk("R10 ref", rd_ref, (i == 2));
    end

    // R8: fill same cycle as write hit on the same entry
    @(negedge clk);
    fill_en = 1'b1; fill_idx = 2'd3; fill_vpn = 20'hC0003; fill_ppn = 16'h1111; fill_wr_ok = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_vaddr = 32'hC0003004;
    @(negedge clk);
    fill_en = 1'b0; req_valid = 1'b0;
    chk("R8 old answer", {code(), rsp_paddr}, {2'd1, 28'h8003004});
    rd_idx = 2'd3; #1;
    chk("R8 fill wins", {rd_dirty, rd_ref, rd_ppn}, {2'b00, 16'h1111});

    // R11: duplicate VPN in entries 2 and 3
    fill(2, 20'h12345, 16'h2222, 1'b1);
    fill(3, 20'h12345, 16'h3333, 1'b1);
    lookup(1'b1, 32'h12345ABC);
    chk("R11 lowest", rsp_paddr, 28'h2222ABC);
    rd_idx = 2'd3; #1;
    chk("R11 other untouched", {rd_dirty, rd_ref}, 2'b00);
    rd_idx = 2'd2; #1;
    chk("R11 chosen updated", {rd_dirty, rd_ref}, 2'b11);

    // R9: invalidate with same-cycle fill
    @(negedge clk);
    inval_all = 1'b1; fill_en = 1'b1; fill_idx = 2'd0; fill_vpn = 20'hAAAAA; fill_ppn = 16'h5555;
    @(negedge clk);
    inval_all = 1'b0; fill_en = 1'b0;
    for (int i = 0; i < N; i++) begin
      rd_idx = 2'(i); #1;
      chk("R9 invalid", rd_valid, 1'b0);
    end
    lookup(1'b0, 32'hC0006123);
    chk("R9 miss", {code(), rsp_paddr}, {2'd2, 28'h0});
    lookup(1'b0, 32'hAAAAA000);
    chk("R9 fill lost", code(), 2'd2);

    finish_run();
  end
endmodule